// File: doc/BRIEF.md
# Loss-of-Clock Supervisor

This block sits beside a PLL and watches the two clocks that reach its phase detector: the reference clock and the divided feedback clock. A free-running monitor clock samples both through synchronizers. When either one shows no edge for a programmable number of monitor cycles, that clock counts as lost. The block then chooses the system clock source and drives the matching PLL controls. That choice holds until the next reset.

A lost reference always takes precedence, whether it fails alone, fails together with the feedback, or fails after the feedback. In each of these cases the block moves to the self-clocked PLL. If only the feedback is lost, the block moves to the PLL reference and stays there even if the feedback returns. When the loss-of-clock reset is enabled, any detected loss instead requests a reset, selects the internal RC oscillator and shuts the PLL off. Only the select and control signals are computed here; the analog loop and the glitch-free multiplexer are outside this block.

Top module: `clk_loss_supervisor`

## Requirements
- R1: After reset, `clk_sel` is 2'b00 (PLL output), `clk_run` is 1, and `scm_active`, `div_log2`, `fm_disable`, `reset_req`, `pll_shutdown` and `fail_seen` are all 0.
- R2: No loss is acted on or recorded until `pll_locked` has been high for at least one cycle after reset. Once seen, lock stays remembered until reset.
- R3: A lost reference with `scm_ok` high gives `clk_sel` = 2'b10 (self-clocked PLL), `scm_active` = 1, `div_log2` = 2 (forced divide-by-4) and `fm_disable` = 1. This state holds until reset.
- R4: A lost feedback while the reference is alive gives `clk_sel` = 2'b01 (PLL reference). This selection holds even after feedback edges return.
- R5: The reference failure wins over the feedback failure. If both are lost together, or the feedback is lost first and the reference later, the result is the self-clocked state of R3.
- R6: If `scm_ok` is low when the reference is lost, or falls while self-clocked, `clk_run` drops to 0 (no clock selected) and stays 0 until reset.
- R7: With `locrst_en` high, any detected loss sets `reset_req` = 1, `pll_shutdown` = 1 and `clk_sel` = 2'b11 (internal RC oscillator). All three hold until reset.
- R8: While `pll_off` is high, `clk_sel` is 2'b01 (external clock path) and losses neither change the selection nor set `fail_seen`.
- R9: A clock is declared lost only after a gap of at least `timeout` monitor cycles with no edge. The outputs react within `timeout`+8 cycles of the last edge.
- R10: `fail_seen[0]` records a lost reference and `fail_seen[1]` a lost feedback. Each bit is sticky until reset, so both set means both failures were seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock, sampled as data |
| fb_clk_in | input | 1 | Divided feedback clock, sampled as data |
| pll_locked | input | 1 | PLL lock indication, arms detection |
| pll_off | input | 1 | PLL disabled, external clock drives the system |
| locrst_en | input | 1 | Loss of clock requests a reset |
| scm_ok | input | 1 | Self-clocked operation is running |
| timeout | input | TO_W | Edge-free monitor cycles that mean loss |
| clk_sel | output | 2 | Source: 00 PLL, 01 reference, 10 self-clocked, 11 RC oscillator |
| clk_run | output | 1 | A clock source is active |
| scm_active | output | 1 | Self-clocked mode flag |
| div_log2 | output | 3 | Forced divider exponent (2 = divide-by-4), 0 when not forced |
| fm_disable | output | 1 | Frequency modulation disabled |
| reset_req | output | 1 | Loss-of-clock reset request |
| pll_shutdown | output | 1 | Turn the PLL off |
| fail_seen | output | 2 | Sticky failures: bit0 reference, bit1 feedback |

## Verification
The bench stops the reference alone, the feedback alone, both at once, and the feedback followed by the reference. This separates the reference-priority rule from plain arrival order. One run restarts the feedback after it was declared lost, which shows that the selection is sticky and does not track the live clock. Further runs apply the same stop patterns before lock, with `pll_off` high, with `scm_ok` low, and with `locrst_en` high; each of these must override the normal choice in its own way. A sample just before the timeout and another just after it bound when a loss is declared.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_REFSEL = 3'd1,
    ST_SCM    = 3'd2,
    ST_HALT   = 3'd3,
    ST_IRC    = 3'd4
  } sup_state_t;

  localparam logic [1:0] SEL_PLL = 2'b00;
  localparam logic [1:0] SEL_REF = 2'b01;
  localparam logic [1:0] SEL_SCM = 2'b10;
  localparam logic [1:0] SEL_IRC = 2'b11;

  localparam int NUM_WATCH = 2;
  localparam int IDX_REF   = 0;
  localparam int IDX_FB    = 1;
  localparam logic [2:0] DIV_SCM_LOG2 = 3'd2;
endpackage

// File: rtl/clk_activity_watch.sv
module clk_activity_watch #(
  parameter int TO_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            sig_in,
  input  logic [TO_W-1:0] timeout,
  output logic            lost
);
  localparam logic [TO_W-1:0] CNT_MAX = {TO_W{1'b1}};

  logic [SYNC_N:0] sh_q;
  logic [TO_W-1:0] gap_q;
  logic            edge_seen;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_N-1:0], sig_in};
  end

  assign edge_seen = sh_q[SYNC_N] ^ sh_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst || !en || edge_seen) gap_q <= '0;
    else if (gap_q != CNT_MAX)   gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lost <= 1'b0;
    else     lost <= en && !edge_seen && (gap_q >= timeout);
  end
endmodule

// File: rtl/clk_loss_fsm.sv
module clk_loss_fsm
  import clk_loss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_lost,
  input  logic       fb_lost,
  input  logic       pll_locked,
  input  logic       pll_off,
  input  logic       locrst_en,
  input  logic       scm_ok,
  output logic       mon_en,
  output logic [1:0] clk_sel,
  output logic       clk_run,
  output logic       scm_active,
  output logic [2:0] div_log2,
  output logic       fm_disable,
  output logic       reset_req,
  output logic       pll_shutdown,
  output logic [1:0] fail_seen
);
  sup_state_t state_q, state_d;
  logic       armed_q;
  logic [1:0] seen_d;

  assign mon_en = armed_q && !pll_off;

  always_comb begin
    state_d = state_q;
    if (mon_en) begin
      unique case (state_q)
        ST_RUN: begin
          if ((ref_lost || fb_lost) && locrst_en) state_d = ST_IRC;
          else if (ref_lost)                      state_d = scm_ok ? ST_SCM : ST_HALT;
          else if (fb_lost)                       state_d = ST_REFSEL;
        end
        ST_REFSEL: begin
          if (ref_lost) begin
            if (locrst_en)   state_d = ST_IRC;
            else if (scm_ok) state_d = ST_SCM;
            else             state_d = ST_HALT;
          end
        end
        ST_SCM:  if (!scm_ok) state_d = ST_HALT;
        default: state_d = state_q;
      endcase
    end
  end

  assign seen_d = fail_seen | ({fb_lost, ref_lost} & {2{mon_en}});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      armed_q      <= 1'b0;
      clk_sel      <= SEL_PLL;
      clk_run      <= 1'b1;
      scm_active   <= 1'b0;
      div_log2     <= '0;
      fm_disable   <= 1'b0;
      reset_req    <= 1'b0;
      pll_shutdown <= 1'b0;
      fail_seen    <= '0;
    end else begin
      state_q      <= state_d;
      armed_q      <= armed_q | pll_locked;
      fail_seen    <= seen_d;
      scm_active   <= (state_d == ST_SCM);
      div_log2     <= (state_d == ST_SCM) ? DIV_SCM_LOG2 : 3'd0;
      fm_disable   <= (state_d == ST_SCM);
      clk_run      <= (state_d != ST_HALT);
      reset_req    <= (state_d == ST_IRC);
      pll_shutdown <= (state_d == ST_IRC);
      unique case (state_d)
        ST_RUN:    clk_sel <= pll_off ? SEL_REF : SEL_PLL;
        ST_REFSEL: clk_sel <= SEL_REF;
        ST_SCM:    clk_sel <= SEL_SCM;
        ST_HALT:   clk_sel <= SEL_SCM;
        default:   clk_sel <= SEL_IRC;
      endcase
    end
  end
endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
  import clk_loss_pkg::*;
#(
  parameter int TO_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_clk_in,
  input  logic            fb_clk_in,
  input  logic            pll_locked,
  input  logic            pll_off,
  input  logic            locrst_en,
  input  logic            scm_ok,
  input  logic [TO_W-1:0] timeout,
  output logic [1:0]      clk_sel,
  output logic            clk_run,
  output logic            scm_active,
  output logic [2:0]      div_log2,
  output logic            fm_disable,
  output logic            reset_req,
  output logic            pll_shutdown,
  output logic [1:0]      fail_seen
);
  logic [NUM_WATCH-1:0] watch_in;
  logic [NUM_WATCH-1:0] watch_lost;
  logic                 mon_en;

  assign watch_in[IDX_REF] = ref_clk_in;
  assign watch_in[IDX_FB]  = fb_clk_in;

  for (genvar gi = 0; gi < NUM_WATCH; gi++) begin : g_watch
    clk_activity_watch #(.TO_W(TO_W), .SYNC_N(SYNC_N)) u_watch (
      .clk     (clk),
      .rst     (rst),
      .en      (mon_en),
      .sig_in  (watch_in[gi]),
      .timeout (timeout),
      .lost    (watch_lost[gi])
    );
  end

  clk_loss_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ref_lost     (watch_lost[IDX_REF]),
    .fb_lost      (watch_lost[IDX_FB]),
    .pll_locked   (pll_locked),
    .pll_off      (pll_off),
    .locrst_en    (locrst_en),
    .scm_ok       (scm_ok),
    .mon_en       (mon_en),
    .clk_sel      (clk_sel),
    .clk_run      (clk_run),
    .scm_active   (scm_active),
    .div_log2     (div_log2),
    .fm_disable   (fm_disable),
    .reset_req    (reset_req),
    .pll_shutdown (pll_shutdown),
    .fail_seen    (fail_seen)
  );
endmodule

// File: rtl/clk_loss_supervisor_chk.sv
module clk_loss_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       scm_ok,
  input logic [1:0] clk_sel,
  input logic       clk_run,
  input logic       scm_active,
  input logic [2:0] div_log2,
  input logic       fm_disable,
  input logic       reset_req,
  input logic       pll_shutdown,
  input logic [1:0] fail_seen
);
  assert_scm_forces_div_R3: assert property (@(posedge clk) disable iff (rst)
    scm_active |-> (div_log2 == 3'd2) && fm_disable && (clk_sel == 2'b10));

  assert_scm_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (scm_active && scm_ok) |=> scm_active || !clk_run);

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_run |=> !clk_run);

  assert_irc_controls_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> pll_shutdown && (clk_sel == 2'b11));

  assert_irc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  assert_ref_seen_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    fail_seen[0] |=> fail_seen[0]);

  assert_fb_seen_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    fail_seen[1] |=> fail_seen[1]);
endmodule

bind clk_loss_supervisor clk_loss_supervisor_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .scm_ok       (scm_ok),
  .clk_sel      (clk_sel),
  .clk_run      (clk_run),
  .scm_active   (scm_active),
  .div_log2     (div_log2),
  .fm_disable   (fm_disable),
  .reset_req    (reset_req),
  .pll_shutdown (pll_shutdown),
  .fail_seen    (fail_seen)
);

// File: tb/clk_loss_supervisor_bench.sv
module clk_loss_supervisor_bench;
  localparam int TO_W = 8;
  localparam int TMO  = 16;

  typedef struct {
    logic [1:0] sel;
    logic       run;
    logic       scm;
    logic [2:0] div;
    logic       fm;
    logic       rr;
    logic       sd;
    logic [1:0] seen;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic ref_run = 1'b1, fb_run = 1'b1;
  logic pll_locked = 1'b0, pll_off = 1'b0, locrst_en = 1'b0, scm_ok = 1'b1;
  logic [TO_W-1:0] timeout = TO_W'(TMO);
  logic [1:0] clk_sel, fail_seen;
  logic clk_run, scm_active, fm_disable, reset_req, pll_shutdown;
  logic [2:0] div_log2;
  logic ph = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  clk_loss_supervisor #(.TO_W(TO_W)) u_clk_loss_supervisor (
    .clk(clk), .rst(rst), .ref_clk_in(ref_in), .fb_clk_in(fb_in),
    .pll_locked(pll_locked), .pll_off(pll_off), .locrst_en(locrst_en),
    .scm_ok(scm_ok), .timeout(timeout), .clk_sel(clk_sel), .clk_run(clk_run),
    .scm_active(scm_active), .div_log2(div_log2), .fm_disable(fm_disable),
    .reset_req(reset_req), .pll_shutdown(pll_shutdown), .fail_seen(fail_seen)
  );

  always @(negedge clk) begin
    ph <= ~ph;
    if (ref_run && ph) ref_in <= ~ref_in;
    if (fb_run && ph)  fb_in  <= ~fb_in;
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (clk_sel !== e.sel || clk_run !== e.run || scm_active !== e.scm ||
          div_log2 !== e.div || fm_disable !== e.fm || reset_req !== e.rr ||
          pll_shutdown !== e.sd || fail_seen !== e.seen) begin
        n_fail++;
        $display("FAIL %s: got sel=%b run=%b scm=%b div=%0d fm=%b rr=%b sd=%b seen=%b, expected sel=%b run=%b scm=%b div=%0d fm=%b rr=%b sd=%b seen=%b",
          e.tag, clk_sel, clk_run, scm_active, div_log2, fm_disable, reset_req,
          pll_shutdown, fail_seen, e.sel, e.run, e.scm, e.div, e.fm, e.rr,
          e.sd, e.seen);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [1:0] sel, input logic run,
      input logic scm, input logic [1:0] seen, input string tag);
    exp_t e;
    e.sel = sel; e.run = run; e.scm = scm;
    e.div = scm ? 3'd2 : 3'd0; e.fm = scm;
    e.rr = (sel == 2'b11); e.sd = (sel == 2'b11);
    e.seen = seen; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    cycles(1);
  endtask

  task automatic start(input logic off, input logic lrst, input logic sok,
      input logic lock);
    rst = 1'b1; ref_run = 1'b1; fb_run = 1'b1; pll_locked = 1'b0;
    pll_off = off; locrst_en = lrst; scm_ok = sok;
    cycles(4);
    rst = 1'b0;
    cycles(8);
    pll_locked = lock;
    cycles(8);
  endtask

  initial begin
    start(1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(2'b00, 1, 0, 2'b00, "R1 reset state");
    ref_run = 1'b0; fb_run = 1'b0;
    cycles(TMO + 24);
    expect_out(2'b00, 1, 0, 2'b00, "R2 loss ignored before lock");
    pll_locked = 1'b1;
    cycles(2);
    pll_locked = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b10, 1, 1, 2'b11, "R2 armed after lock pulse");

    start(1'b0, 1'b0, 1'b1, 1'b1);
    ref_run = 1'b0;
    cycles(TMO - 4);
    expect_out(2'b00, 1, 0, 2'b00, "R9 no loss before timeout");
    cycles(14);
    expect_out(2'b10, 1, 1, 2'b01, "R3 R9 reference loss to self-clocked");
    ref_run = 1'b1;
    cycles(20);
    expect_out(2'b10, 1, 1, 2'b01, "R3 self-clocked sticky after reference returns");

    start(1'b0, 1'b0, 1'b1, 1'b1);
    fb_run = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b01, 1, 0, 2'b10, "R4 feedback loss selects reference");
    fb_run = 1'b1;
    cycles(30);
    expect_out(2'b01, 1, 0, 2'b10, "R4 reference kept after feedback returns");
    ref_run = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b10, 1, 1, 2'b11, "R5 feedback first then reference");

    start(1'b0, 1'b0, 1'b1, 1'b1);
    ref_run = 1'b0; fb_run = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b10, 1, 1, 2'b11, "R5 R10 both lost together");

    start(1'b0, 1'b0, 1'b0, 1'b1);
    ref_run = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b10, 0, 0, 2'b01, "R6 self-clocked unavailable halts");
    scm_ok = 1'b1; ref_run = 1'b1;
    cycles(20);
    expect_out(2'b10, 0, 0, 2'b01, "R6 halt sticky");

    start(1'b0, 1'b0, 1'b1, 1'b1);
    ref_run = 1'b0;
    cycles(TMO + 12);
    scm_ok = 1'b0;
    cycles(3);
    expect_out(2'b10, 0, 0, 2'b01, "R6 self-clocked drops out");

    start(1'b0, 1'b1, 1'b1, 1'b1);
    fb_run = 1'b0;
    cycles(TMO + 12);
    expect_out(2'b11, 1, 0, 2'b10, "R7 loss with reset enabled");
    fb_run = 1'b1; locrst_en = 1'b0;
    cycles(20);
    expect_out(2'b11, 1, 0, 2'b10, "R7 RC oscillator sticky");

    start(1'b1, 1'b0, 1'b1, 1'b1);
    expect_out(2'b01, 1, 0, 2'b00, "R8 PLL off selects external");
    ref_run = 1'b0; fb_run = 1'b0;
    cycles(TMO + 24);
    expect_out(2'b01, 1, 0, 2'b00, "R8 losses ignored with PLL off");

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule